// File: doc/BRIEF.md
# Shift-Based Row Redundancy Remapper

This block sits in front of a 128-word by 32-bit memory array and translates each logical word address into the physical row that has to be driven. The array is built as two banks, and each bank carries one redundant row placed after its last normal row. Each bank has its own fuse set: an active-high enable and a 6-bit row index. When a bank's fuse is enabled, the faulty row and every row after it in that bank move one position toward the spare. The last normal row therefore lands on the spare row, and the faulty row is never selected again.

Address bit 5 picks the bank: 0 for the top bank, 1 for the bottom bank. The remaining six address bits form the in-bank index. Address bit 6 is index bit 5, and address bits 4..0 are index bits 4..0. A fuse row value uses the same layout. The result appears one clock after the request as a 7-bit physical row number plus one spare-select flag per bank. The row number is given in address form, with the bank bit put back at position 5. The block holds no state of its own besides this output register, so the fuse inputs are expected to be stable while requests are presented.

Top module: `rowrep_remap`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, rsp_valid, rsp_row and rsp_spare are all zero, whatever req_valid shows.
- R2: rsp_valid equals req_valid from the previous rising edge. When rsp_valid is low, rsp_row and rsp_spare are zero.
- R3: Address bit 5 selects the bank (0 = top, 1 = bottom). The in-bank index is {addr[6], addr[4:0]}. A fuse row value f is compared in the same layout.
- R4: With a bank's fuse enable low, every address of that bank maps to rsp_row equal to the address, and that bank's spare flag is never raised.
- R5: With a bank's fuse enabled at index f, an access whose in-bank index is below f maps unchanged (rsp_row = address).
- R6: With a bank's fuse enabled at index f, an access whose in-bank index i satisfies f <= i < 63 maps to index i+1 of the same bank: rsp_row = {m[5], bank, m[4:0]} with m = i+1.
- R7: With a bank's fuse enabled, an access to in-bank index 63 selects that bank's spare. rsp_spare bit 0 is the top spare and bit 1 is the bottom spare. rsp_row is zero when a spare is selected.
- R8: At most one rsp_spare bit is set, and only the bit of the accessed bank.
- R9: One bank's fuse setting has no effect on the mapping of the other bank's addresses.
- R10: With a bank's fuse enabled at index f, the 64 addresses of that bank reach 64 distinct physical targets. None of them is the normal row at index f.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 7 | Logical word address |
| fuse_en_top | input | 1 | Repair enable for the top bank |
| fuse_row_top | input | 6 | Faulty in-bank index, top bank |
| fuse_en_bot | input | 1 | Repair enable for the bottom bank |
| fuse_row_bot | input | 6 | Faulty in-bank index, bottom bank |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_row | output | 7 | Physical normal row, in address form |
| rsp_spare | output | 2 | Spare row select, bit 0 top, bit 1 bottom |

## Verification
In a single access, the shift toward the spare and the spare selection itself can coincide. This happens when the fuse sits at index 63 and index 63 is read, or when the fuse is at 0, which shifts the whole bank. The bench sweeps every fuse index against all 128 addresses under all four enable combinations. The two banks' fuses take different values in each run, so a shift in one bank always overlaps the identity path or a differently placed shift in the other bank. Each response is compared with a model computed arithmetically from R3 to R7. The bench also tracks every physical target per sweep, which shows duplicate or faulty-row hits for R10.

// File: rtl/rowrep_pkg.sv
package rowrep_pkg;
    localparam int ROW_ADDR_W   = 7;
    localparam int BANK_SEL_BIT = 5;
    localparam int IDX_W        = ROW_ADDR_W - 1;
    localparam int NUM_BANKS    = 2;
    localparam int MAP_W        = IDX_W + 1;

    typedef struct packed {
        logic                  valid;
        logic [ROW_ADDR_W-1:0] row;
        logic [NUM_BANKS-1:0]  spare;
    } rsp_t;
endpackage

// File: rtl/rowrep_addr_split.sv
module rowrep_addr_split #(
    parameter int ADDR_W  = rowrep_pkg::ROW_ADDR_W,
    parameter int SEL_BIT = rowrep_pkg::BANK_SEL_BIT,
    localparam int IW     = ADDR_W - 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              bank,
    output logic [IW-1:0]     idx
);
    assign bank = addr[SEL_BIT];

    // Remove the bank bit; higher bits slide down by one.
    for (genvar i = 0; i < IW; i++) begin : g_idx
        if (i < SEL_BIT) begin : g_low
            assign idx[i] = addr[i];
        end else begin : g_high
            assign idx[i] = addr[i+1];
        end
    end
endmodule

// File: rtl/rowrep_bank_map.sv
module rowrep_bank_map #(
    parameter int IW = rowrep_pkg::IDX_W
) (
    input  logic          en,
    input  logic [IW-1:0] fuse_idx,
    input  logic [IW-1:0] acc_idx,
    output logic          hit,
    output logic [IW:0]   map_idx
);
    // At or past the faulty index, move one slot toward the spare.
    always_comb begin
        hit     = en && (acc_idx >= fuse_idx);
        map_idx = {1'b0, acc_idx} + {{IW{1'b0}}, hit};
    end
endmodule

// File: rtl/rowrep_row_join.sv
module rowrep_row_join #(
    parameter int ADDR_W  = rowrep_pkg::ROW_ADDR_W,
    parameter int SEL_BIT = rowrep_pkg::BANK_SEL_BIT,
    parameter int BANKS   = rowrep_pkg::NUM_BANKS,
    localparam int IW     = ADDR_W - 1
) (
    input  logic              bank,
    input  logic [IW:0]       map_idx,
    output logic [ADDR_W-1:0] row,
    output logic [BANKS-1:0]  spare
);
    logic              to_spare;
    logic [ADDR_W-1:0] joined;

    assign to_spare = map_idx[IW];

    // Put the bank bit back at its position.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_row
        if (i < SEL_BIT) begin : g_low
            assign joined[i] = map_idx[i];
        end else if (i == SEL_BIT) begin : g_sel
            assign joined[i] = bank;
        end else begin : g_high
            assign joined[i] = map_idx[i-1];
        end
    end

    assign row = to_spare ? '0 : joined;

    for (genvar b = 0; b < BANKS; b++) begin : g_spare
        assign spare[b] = to_spare && (bank == 1'(b));
    end
endmodule

// File: rtl/rowrep_remap.sv
module rowrep_remap
    import rowrep_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ROW_ADDR_W-1:0] req_addr,
    input  logic                  fuse_en_top,
    input  logic [IDX_W-1:0]      fuse_row_top,
    input  logic                  fuse_en_bot,
    input  logic [IDX_W-1:0]      fuse_row_bot,
    output logic                  rsp_valid,
    output logic [ROW_ADDR_W-1:0] rsp_row,
    output logic [NUM_BANKS-1:0]  rsp_spare
);
    logic                  acc_bank;
    logic [IDX_W-1:0]      acc_idx;
    logic [NUM_BANKS-1:0]  fuse_en_arr;
    logic [IDX_W-1:0]      fuse_arr [NUM_BANKS];
    logic [NUM_BANKS-1:0]  bank_hit;
    logic [MAP_W-1:0]      bank_map [NUM_BANKS];
    logic [MAP_W-1:0]      sel_map;
    logic [ROW_ADDR_W-1:0] nxt_row;
    logic [NUM_BANKS-1:0]  nxt_spare;
    rsp_t                  rsp_q;

    assign fuse_en_arr = {fuse_en_bot, fuse_en_top};
    assign fuse_arr[0] = fuse_row_top;
    assign fuse_arr[1] = fuse_row_bot;

    rowrep_addr_split u_split (
        .addr (req_addr),
        .bank (acc_bank),
        .idx  (acc_idx)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        rowrep_bank_map u_map (
            .en       (fuse_en_arr[b]),
            .fuse_idx (fuse_arr[b]),
            .acc_idx  (acc_idx),
            .hit      (bank_hit[b]),
            .map_idx  (bank_map[b])
        );

        // R10
        faulty_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fuse_en_arr[b] |-> (bank_map[b] != {1'b0, fuse_arr[b]}));
    end

    assign sel_map = bank_map[acc_bank];

    rowrep_row_join u_join (
        .bank    (acc_bank),
        .map_idx (sel_map),
        .row     (nxt_row),
        .spare   (nxt_spare)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else if (req_valid) begin
            rsp_q <= '{valid: 1'b1, row: nxt_row, spare: nxt_spare};
        end else begin
            rsp_q <= '0;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_row   = rsp_q.row;
    assign rsp_spare = rsp_q.spare;

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_row == '0 && rsp_spare == '0));

    // R8
    spare_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_spare));

    // R4
    top_spare_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_spare[0] |-> ($past(fuse_en_top) && !$past(req_addr[BANK_SEL_BIT])));

    // R4
    bot_spare_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_spare[1] |-> ($past(fuse_en_bot) && $past(req_addr[BANK_SEL_BIT])));

    // R7
    spare_row_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_spare != '0) |-> (rsp_valid && rsp_row == '0));
endmodule

// File: tb/rowrep_remap_tb.sv
module rowrep_remap_tb;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [6:0] req_addr = '0;
    logic       fuse_en_top = 1'b0;
    logic [5:0] fuse_row_top = '0;
    logic       fuse_en_bot = 1'b0;
    logic [5:0] fuse_row_bot = '0;
    logic       rsp_valid;
    logic [6:0] rsp_row;
    logic [1:0] rsp_spare;

    int total = 0;
    int bad = 0;
    bit used [130];

    always #(PERIOD/2) clk = ~clk;

    rowrep_remap u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .fuse_en_top  (fuse_en_top),
        .fuse_row_top (fuse_row_top),
        .fuse_en_bot  (fuse_en_bot),
        .fuse_row_bot (fuse_row_bot),
        .rsp_valid    (rsp_valid),
        .rsp_row      (rsp_row),
        .rsp_spare    (rsp_spare)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // One request; the response is sampled a quarter period after the edge.
    task automatic access(input int a, input string tag);
        int bk, idx, en, f, m, exp_row, exp_sp, tgt, faulty;
        bk  = (a >> 5) & 1;
        idx = ((a >> 6) & 1) * 32 + (a & 31);
        en  = bk ? fuse_en_bot : fuse_en_top;
        f   = bk ? fuse_row_bot : fuse_row_top;
        m   = (en != 0 && idx >= f) ? idx + 1 : idx;
        if (m == 64) begin
            exp_row = 0;
            exp_sp  = 1 << bk;
            tgt     = 128 + bk;
        end else begin
            exp_row = (m / 32) * 64 + bk * 32 + (m % 32);
            exp_sp  = 0;
            tgt     = exp_row;
        end
        req_valid = 1'b1;
        req_addr  = 7'(a);
        @(posedge clk);
        #(PERIOD/4);
        check(rsp_valid == 1'b1, "R2 valid", int'(rsp_valid), 1);
        check(int'(rsp_row) == exp_row, tag, int'(rsp_row), exp_row);
        check(int'(rsp_spare) == exp_sp, "R7/R8 spare", int'(rsp_spare), exp_sp);
        if (en != 0) begin
            faulty = (f / 32) * 64 + bk * 32 + (f % 32);
            check(!(rsp_spare == 0 && int'(rsp_row) == faulty), "R10 faulty row reached",
                  int'(rsp_row), faulty);
            check(!used[tgt], "R10 duplicate target", tgt, -1);
        end
        used[tgt] = 1'b1;
    endtask

    initial begin
        #(PERIOD*150000);
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", total, -1);
        summary();
    end

    initial begin
        // R1: reset holds outputs at zero even with a request present
        req_valid = 1'b1;
        req_addr  = 7'h7f;
        fuse_en_top = 1'b1;
        fuse_row_top = 6'd63;
        repeat (3) @(posedge clk);
        #(PERIOD/4);
        check(rsp_valid == 0, "R1 valid in reset", int'(rsp_valid), 0);
        check(rsp_row == 0, "R1 row in reset", int'(rsp_row), 0);
        check(rsp_spare == 0, "R1 spare in reset", int'(rsp_spare), 0);
        rst_n = 1'b1;
        req_valid = 1'b0;
        @(posedge clk);
        #(PERIOD/4);
        check(rsp_valid == 0 && rsp_row == 0 && rsp_spare == 0, "R1 first cycle",
              int'(rsp_valid), 0);

        // Sweep: all enable combinations, every fuse index, every address.
        // R3 R4 R5 R6 R7 R9 R10 are judged by the arithmetic model in access().
        for (int mode = 0; mode < 4; mode++) begin
            for (int ft = 0; ft < 64; ft++) begin
                fuse_en_top  = mode[0];
                fuse_en_bot  = mode[1];
                fuse_row_top = 6'(ft);
                fuse_row_bot = 6'((ft * 5 + 3) % 64);
                for (int k = 0; k < 130; k++) used[k] = 1'b0;
                for (int a = 0; a < 128; a++) begin
                    access(a, "R3/R4/R5/R6/R9 row");
                end
            end
        end

        // R7: fuse at the last index, the last index goes to the spare
        fuse_en_top = 1'b1; fuse_row_top = 6'd63;
        fuse_en_bot = 1'b1; fuse_row_bot = 6'd63;
        for (int k = 0; k < 130; k++) used[k] = 1'b0;
        access(7'h5f, "R7 top last index");
        access(7'h7f, "R7 bottom last index");
        access(7'h5e, "R5 top below fuse");

        // R2: idle cycle clears the outputs
        req_valid = 1'b0;
        @(posedge clk);
        #(PERIOD/4);
        check(rsp_valid == 0, "R2 idle valid", int'(rsp_valid), 0);
        check(rsp_row == 0 && rsp_spare == 0, "R2 idle payload", int'(rsp_row), 0);

        summary();
    end
endmodule